// File: doc/BRIEF.md
# Byte-wide asynchronous SRAM controller

This block sits between a clocked host and an external 512K x 8 asynchronous static memory. The host hands it one read or one write at a time over a valid/ready handshake. The controller then produces the chip-select, write-strobe and read-strobe waveforms on the memory pins, and it drives the 19-bit address. It reports the end of every access with a single-cycle `done` pulse. For a read, the fetched byte appears on `rdata` in the same cycle as that pulse.

Every phase of an access lasts a whole number of clock cycles, and a parameter sets that number for each phase. The same RTL can therefore be fitted to a slower or faster memory grade by changing the parameters alone. Each phase is at least one cycle long.

- A write runs through address setup (`ST_WSETUP`), the strobe pulse (`ST_WPULSE`), data hold (`ST_WHOLD`) and recovery (`ST_WRECOV`).
- A read runs through a bus-turnaround cycle (`ST_RTURN`) and then the access window (`ST_RACCESS`).

The data bus is split into three ports: the outgoing byte, a drive enable and the incoming byte. The pad tri-state buffer sits outside this block.

State transitions:

| From | To | Condition |
| --- | --- | --- |
| `ST_IDLE` | `ST_WSETUP` | a write request is accepted |
| `ST_IDLE` | `ST_RTURN` | a read request is accepted |
| `ST_WSETUP` | `ST_WPULSE` | phase timer expired |
| `ST_WPULSE` | `ST_WHOLD` | phase timer expired |
| `ST_WHOLD` | `ST_WRECOV` | phase timer expired |
| `ST_WRECOV` | `ST_IDLE` | phase timer expired; raises `done` |
| `ST_RTURN` | `ST_RACCESS` | after exactly one cycle |
| `ST_RACCESS` | `ST_IDLE` | phase timer expired; captures the data and raises `done` |

Top module: `sramc_ctrl`

## Requirements
- R1: While reset is asserted and while idle, `mem_ce_n`, `mem_we_n` and `mem_oe_n` are 1. In the same conditions `mem_dq_oe` and `done` are 0 and `req_ready` is 1.
- R2: A request is taken only on a rising clock edge where `req_valid` and `req_ready` are both 1. `req_ready` is 0 from the cycle after acceptance until the cycle in which `done` is raised. A request presented while busy has no effect on the memory.
- R3: An accepted write (`req_we`=1) drives the following, counting from the cycle after acceptance:
  - `mem_ce_n`=0 with `mem_we_n`=1 for T_SETUP cycles;
  - then `mem_we_n`=0 for T_WPULSE cycles;
  - then `mem_we_n`=1 with `mem_ce_n` still 0 for T_HOLD cycles;
  - then all strobes at 1 for T_RECOV cycles.

  The byte on `mem_dq_o` is the one stored at `mem_addr`.
- R4: `mem_oe_n` is 1 throughout every write, and `mem_we_n` is 0 only while `mem_ce_n` is 0.
- R5: `mem_dq_oe` is 1 only during the strobe-pulse and data-hold phases of a write. It is still 1 in the cycle where `mem_we_n` returns to 1.
- R6: An accepted read (`req_we`=0) first gives one cycle with `mem_ce_n`=0, `mem_oe_n`=1 and `mem_dq_oe`=0. It then gives T_ACCESS cycles with `mem_ce_n`=0 and `mem_oe_n`=0. The byte on `mem_dq_i` at the end of the last access cycle is the read result.
- R7: `done` is 1 for exactly one cycle:
  - for a write, T_SETUP+T_WPULSE+T_HOLD+T_RECOV+1 cycles after the accepting edge;
  - for a read, T_ACCESS+2 cycles after the accepting edge, with `rdata` holding the result in that cycle.
- R8: `mem_addr` does not change while `mem_ce_n` stays 0.
- R9: `req_ready` is 1 in the `done` cycle, so a request held valid is accepted on the edge that ends that cycle (back-to-back).

## Ports
| Port | Direction | Width | Description |
| --- | --- | --- | --- |
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller idle, request can be taken |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W (19) | Byte address |
| req_wdata | input | DATA_W (8) | Write byte |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | DATA_W (8) | Read result, valid with `done` after a read |
| mem_ce_n | output | 1 | Memory chip select, active low |
| mem_we_n | output | 1 | Memory write strobe, active low |
| mem_oe_n | output | 1 | Memory read strobe, active low |
| mem_addr | output | ADDR_W (19) | Memory address bus |
| mem_dq_o | output | DATA_W (8) | Byte driven onto the data bus |
| mem_dq_oe | output | 1 | Drive enable for the data-bus pads |
| mem_dq_i | input | DATA_W (8) | Byte sampled from the data bus |

## Verification
The interesting collision is the completion of one access and the acceptance of the next, which fall in the same cycle. The bench provokes it by keeping `req_valid` high with the next request while an access is still running, across write-to-read, read-to-read and write-to-write sequences. A reference model built from counters and queues predicts every strobe, `req_ready` and `done` each cycle, and the bench compares the design against it on every clock. A behavioural memory model checks, at the pins, that the second access still sees the strobes go inactive and the data bus released before its read strobe falls, and that the data it returns belongs to the correct request.

// File: rtl/sramc_pkg.sv
package sramc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_WSETUP  = 3'd1,
        ST_WPULSE  = 3'd2,
        ST_WHOLD   = 3'd3,
        ST_WRECOV  = 3'd4,
        ST_RTURN   = 3'd5,
        ST_RACCESS = 3'd6
    } sramc_state_e;

    function automatic int unsigned umax(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sramc_phase_timer.sv
module sramc_phase_timer #(
    parameter int unsigned CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/sramc_rd_capture.sv
module sramc_rd_capture #(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout <= '0;
        end else if (capture) begin
            dout <= din;
        end
    end
endmodule

// File: rtl/sramc_ctrl.sv
module sramc_ctrl
    import sramc_pkg::*;
#(
    parameter int unsigned ADDR_W   = 19,
    parameter int unsigned DATA_W   = 8,
    parameter int unsigned T_SETUP  = 1,
    parameter int unsigned T_WPULSE = 6,
    parameter int unsigned T_HOLD   = 1,
    parameter int unsigned T_RECOV  = 1,
    parameter int unsigned T_ACCESS = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_we,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              done,
    output logic [DATA_W-1:0] rdata,
    output logic              mem_ce_n,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dq_o,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_i
);
    localparam int unsigned MAX_LEN =
        umax(umax(umax(T_SETUP, T_WPULSE), umax(T_HOLD, T_RECOV)), T_ACCESS);
    localparam int unsigned CNT_W = (MAX_LEN > 1) ? $clog2(MAX_LEN) : 1;

    sramc_state_e state_q, state_nx;
    logic             phase_done;
    logic             accept;
    logic [CNT_W-1:0] phase_load_val;
    logic             rd_capture;

    function automatic int unsigned phase_len(input sramc_state_e s);
        unique case (s)
            ST_WSETUP:  return T_SETUP;
            ST_WPULSE:  return T_WPULSE;
            ST_WHOLD:   return T_HOLD;
            ST_WRECOV:  return T_RECOV;
            ST_RACCESS: return T_ACCESS;
            default:    return 1;
        endcase
    endfunction

    assign req_ready      = (state_q == ST_IDLE);
    assign accept         = req_ready && req_valid;
    assign phase_load_val = CNT_W'(phase_len(state_nx) - 1);
    assign rd_capture     = (state_q == ST_RACCESS) && phase_done;

    // next-state decode
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_IDLE:    if (req_valid) state_nx = req_we ? ST_WSETUP : ST_RTURN;
            ST_WSETUP:  if (phase_done) state_nx = ST_WPULSE;
            ST_WPULSE:  if (phase_done) state_nx = ST_WHOLD;
            ST_WHOLD:   if (phase_done) state_nx = ST_WRECOV;
            ST_WRECOV:  if (phase_done) state_nx = ST_IDLE;
            ST_RTURN:   state_nx = ST_RACCESS;
            ST_RACCESS: if (phase_done) state_nx = ST_IDLE;
            default:    state_nx = ST_IDLE;
        endcase
    end

    // state register and request latch
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            mem_addr <= '0;
            mem_dq_o <= '0;
        end else begin
            state_q <= state_nx;
            if (accept) begin
                mem_addr <= req_addr;
                mem_dq_o <= req_wdata;
            end
        end
    end

    // registered pin strobes decoded from the coming state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_ce_n  <= 1'b1;
            mem_we_n  <= 1'b1;
            mem_oe_n  <= 1'b1;
            mem_dq_oe <= 1'b0;
            done      <= 1'b0;
        end else begin
            done <= phase_done &&
                    ((state_q == ST_WRECOV) || (state_q == ST_RACCESS));
            unique case (state_nx)
                ST_WSETUP, ST_RTURN: begin
                    mem_ce_n <= 1'b0; mem_we_n <= 1'b1; mem_oe_n <= 1'b1; mem_dq_oe <= 1'b0;
                end
                ST_WPULSE: begin
                    mem_ce_n <= 1'b0; mem_we_n <= 1'b0; mem_oe_n <= 1'b1; mem_dq_oe <= 1'b1;
                end
                ST_WHOLD: begin
                    mem_ce_n <= 1'b0; mem_we_n <= 1'b1; mem_oe_n <= 1'b1; mem_dq_oe <= 1'b1;
                end
                ST_RACCESS: begin
                    mem_ce_n <= 1'b0; mem_we_n <= 1'b1; mem_oe_n <= 1'b0; mem_dq_oe <= 1'b0;
                end
                default: begin
                    mem_ce_n <= 1'b1; mem_we_n <= 1'b1; mem_oe_n <= 1'b1; mem_dq_oe <= 1'b0;
                end
            endcase
        end
    end

    sramc_phase_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (state_nx != state_q),
        .load_val (phase_load_val),
        .expired  (phase_done)
    );

    sramc_rd_capture #(.DATA_W(DATA_W)) u_rcap (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (rd_capture),
        .din     (mem_dq_i),
        .dout    (rdata)
    );
endmodule

// File: rtl/sramc_chk.sv
module sramc_chk #(
    parameter int unsigned ADDR_W = 19
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              done,
    input logic              mem_ce_n,
    input logic              mem_we_n,
    input logic              mem_oe_n,
    input logic              mem_dq_oe,
    input logic [ADDR_W-1:0] mem_addr
);
    // R4
    oe_off_in_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> (mem_oe_n && !mem_ce_n));

    // R5
    dq_drive_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> (mem_oe_n && !mem_ce_n));

    // R3
    data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> (mem_dq_oe && !mem_ce_n));

    // R6
    turnaround_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_oe_n) |-> !$past(mem_dq_oe));

    // R8
    addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr));

    // R7
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9
    done_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> req_ready);
endmodule

bind sramc_ctrl sramc_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .done      (done),
    .mem_ce_n  (mem_ce_n),
    .mem_we_n  (mem_we_n),
    .mem_oe_n  (mem_oe_n),
    .mem_dq_oe (mem_dq_oe),
    .mem_addr  (mem_addr)
);

// File: tb/sramc_ctrl_tb.sv
`timescale 1ns/1ps
module sramc_ctrl_tb;
    localparam int AW = 19;
    localparam int DW = 8;
    localparam int S = 2, P = 3, H = 1, RC = 2, A = 2;
    localparam int WTOT = S + P + H + RC;
    localparam int RTOT = A + 1;

    logic clk = 0, rst_n = 0;
    logic req_valid = 0, req_we = 0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic req_ready, done, mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe;
    logic [DW-1:0] rdata, mem_dq_o;
    logic [DW-1:0] mem_dq_i = 8'hA5;
    logic [AW-1:0] mem_addr;

    int checks = 0, failures = 0, cyc = 0;

    always #5 clk = ~clk;

    sramc_ctrl #(.ADDR_W(AW), .DATA_W(DW), .T_SETUP(S), .T_WPULSE(P),
                 .T_HOLD(H), .T_RECOV(RC), .T_ACCESS(A)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata),
        .done(done), .rdata(rdata), .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n),
        .mem_oe_n(mem_oe_n), .mem_addr(mem_addr), .mem_dq_o(mem_dq_o),
        .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i));

    function automatic logic [7:0] dflt(input logic [AW-1:0] a);
        return a[7:0] ^ a[15:8] ^ {a[18:16], 5'h0} ^ 8'h3C;
    endfunction

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h t=%0t", req, what, act, exp, $time);
        end
    endtask

    // ---------------- reference model (advanced on inputs only) ----------------
    logic [7:0] exp_mem [int];
    bit m_busy = 0, m_we = 0;
    int m_t = 0, m_tot = 0, acc_cnt = 0;
    logic [AW-1:0] m_addr = '0;
    logic [7:0] m_rd = '0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 0; m_t = 0;
        end else begin
            bit idle_now;
            idle_now = !m_busy || (m_t == m_tot + 1);
            if (idle_now && req_valid) begin
                m_busy = 1; m_t = 1; m_we = req_we; m_addr = req_addr;
                m_tot = req_we ? WTOT : RTOT;
                if (req_we) exp_mem[int'(req_addr)] = req_wdata;
                else m_rd = exp_mem.exists(int'(req_addr)) ? exp_mem[int'(req_addr)] : dflt(req_addr);
                acc_cnt++;
            end else if (m_busy && m_t == m_tot + 1) begin
                m_busy = 0;
            end else if (m_busy) begin
                m_t++;
            end
        end
    end

    // ---------------- per-cycle comparison ----------------
    always @(negedge clk) begin
        if (rst_n) begin
            logic e_ce, e_we, e_oe, e_dq, e_done, e_rdy;
            e_ce = 1; e_we = 1; e_oe = 1; e_dq = 0; e_done = 0; e_rdy = 1;
            if (m_busy) begin
                if (m_t == m_tot + 1) e_done = 1;
                else begin
                    e_rdy = 0;
                    if (m_we) begin
                        if (m_t <= S) e_ce = 0;
                        else if (m_t <= S + P) begin e_ce = 0; e_we = 0; e_dq = 1; end
                        else if (m_t <= S + P + H) begin e_ce = 0; e_dq = 1; end
                    end else begin
                        e_ce = 0;
                        if (m_t >= 2) e_oe = 0;
                    end
                end
            end
            chk(m_we ? "R3" : "R6", "mem_ce_n", mem_ce_n, e_ce);
            chk("R3", "mem_we_n", mem_we_n, e_we);
            chk("R4", "mem_oe_n", mem_oe_n, e_oe);
            chk("R5", "mem_dq_oe", mem_dq_oe, e_dq);
            chk("R7", "done", done, e_done);
            chk("R2", "req_ready", req_ready, e_rdy);
            if (!e_ce) chk("R8", "mem_addr", int'(mem_addr), int'(m_addr));
            if (e_done && !m_we) chk("R7", "rdata", rdata, m_rd);
        end
    end

    // ---------------- behavioural memory ----------------
    logic [7:0] mem_arr [int];
    bit prev_wr = 0;
    int wlen = 0;
    logic [7:0] last_d = '0;
    logic [AW-1:0] last_a = '0;

    always @(negedge clk) begin
        bit wr;
        wr = rst_n && !mem_ce_n && !mem_we_n;
        if (wr) begin
            if (!mem_oe_n) begin failures++; $display("FAIL R4 read strobe low during write actual=0 expected=1"); end
            if (!mem_dq_oe) begin failures++; $display("FAIL R5 bus not driven during write actual=0 expected=1"); end
            wlen++; last_d = mem_dq_o; last_a = mem_addr;
        end
        if (prev_wr && !wr) begin
            checks++;
            if (wlen < P) begin failures++; $display("FAIL R3 write pulse actual=%0d expected>=%0d", wlen, P); end
            if (!mem_ce_n) chk("R5", "hold drive", mem_dq_oe, 1);
            mem_arr[int'(last_a)] = last_d;
            wlen = 0;
        end
        prev_wr = wr;
        if (rst_n && !mem_ce_n && !mem_oe_n && mem_we_n)
            mem_dq_i = mem_arr.exists(int'(mem_addr)) ? mem_arr[int'(mem_addr)] : dflt(mem_addr);
        else
            mem_dq_i = 8'hA5;
    end

    // ---------------- stimulus ----------------
    task automatic issue(input bit we, input logic [AW-1:0] a, input logic [7:0] d);
        int start;
        start = acc_cnt;
        req_valid = 1; req_we = we; req_addr = a; req_wdata = d;
        do @(negedge clk); while (acc_cnt == start);
        req_valid = 0;
    endtask

    task automatic wait_idle();
        do @(negedge clk); while (m_busy);
    endtask

    task automatic rd_check(input logic [AW-1:0] a, input logic [7:0] e, input string req);
        issue(0, a, 8'h00);
        do @(negedge clk); while (!(m_busy && m_t == m_tot + 1));
        chk(req, "readback", rdata, e);
    endtask

    initial begin
        logic [AW-1:0] lf;
        lf = 19'h1ACE5;
        repeat (3) @(negedge clk);
        // R1: reset values
        chk("R1", "ce in reset", mem_ce_n, 1);
        chk("R1", "dq_oe in reset", mem_dq_oe, 0);
        chk("R1", "done in reset", done, 0);
        chk("R1", "ready in reset", req_ready, 1);
        rst_n = 1;
        @(negedge clk);
        chk("R1", "we idle", mem_we_n, 1);
        chk("R1", "oe idle", mem_oe_n, 1);

        // R3/R6: single write then read
        issue(1, 19'h12345, 8'h5A); wait_idle();
        rd_check(19'h12345, 8'h5A, "R3");
        // boundaries
        rd_check(19'h00000, dflt(19'h00000), "R6");
        rd_check(19'h7FFFF, dflt(19'h7FFFF), "R6");
        issue(1, 19'h7FFFF, 8'hC3); wait_idle();
        rd_check(19'h7FFFF, 8'hC3, "R6");

        // R9: back-to-back with valid held through done
        begin
            int a0;
            a0 = acc_cnt;
            issue(1, 19'h00100, 8'h11);
            issue(1, 19'h00101, 8'h22);
            issue(0, 19'h00100, 8'h00);
            issue(0, 19'h00101, 8'h00);
            issue(0, 19'h7FFFF, 8'h00);
            wait_idle();
            chk("R9", "accepted count", acc_cnt - a0, 5);
        end
        rd_check(19'h00101, 8'h22, "R9");

        // R2: request pulsed while busy is ignored
        issue(1, 19'h00200, 8'h77);
        @(negedge clk);
        req_valid = 1; req_we = 1; req_addr = 19'h00300; req_wdata = 8'hEE;
        @(negedge clk);
        req_valid = 0;
        wait_idle();
        rd_check(19'h00300, dflt(19'h00300), "R2");
        rd_check(19'h00200, 8'h77, "R2");

        // mixed pattern
        for (int i = 0; i < 24; i++) begin
            lf = {lf[17:0], lf[18] ^ lf[5]};
            issue(lf[0], {lf[18:4], 4'h0} ^ 19'(i), lf[7:0] ^ 8'(i));
            if (i % 3 == 0) wait_idle();
        end
        wait_idle();
        repeat (4) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected<=20000", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule